// File: doc/BRIEF.md
# Transparent-Mode Escape Filter for a Byte-Synchronous Receiver

This block sits after character assembly in a byte-synchronous receive channel. Every time the assembler strobes a finished character in, the filter decides on one of three outcomes:

- drop the character;
- hand it to the buffer writer;
- close the current buffer, possibly flagging an escape error.

Alongside that outcome it marks whether the character takes part in the block-check (CRC or LRC) accumulation. The check arithmetic itself is done elsewhere.

Software programs the filter through several inputs:

- a synchronization character and an escape (DLE) character, each with its own enable flag;
- an eight-entry control-character table, where each entry holds a value, an enable bit and a reject bit;
- a transparent-mode select and a hunt indication.

In transparent mode an enabled escape character is stripped and arms a one-character escape window. The next character is classified in this order:

- a synchronization fill;
- a doubled escape, which is kept as data;
- a control code taken from the table;
- otherwise an illegal follower, which closes the buffer with an error.

Top module: `bsc_xp_filter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `wr_en`, `bc_incl`, `buf_close` and `esc_err` are 0, and no escape window is open.
- R2: All four qualifiers and `out_char` are registered. They answer the strobe of the previous cycle, and all four are 0 in a cycle that follows a cycle with `rx_vld` low.
- R3: A strobed character while `hunt` is high is dropped (all qualifiers 0), and `hunt` closes any open escape window.
- R4: With no escape window open, `hunt` low and `sync_en` set, a character equal to `sync_chr` is dropped and excluded from the check.
- R5: With no escape window open, `xp_mode` high and `esc_en` set, a character equal to `esc_chr` is dropped, excluded, and opens the escape window for the next strobed character.
- R6: Inside the escape window, a character equal to `sync_chr` is dropped and excluded, whatever `sync_en` is. The window then closes.
- R7: Inside the escape window, a character equal to `esc_chr` is written and included. The window then closes.
- R8: Inside the escape window, any other character is looked up among the enabled table entries, and the lowest-numbered matching entry wins. Entry g occupies `tbl_val[8g+7:8g]`, `tbl_en[g]` and `tbl_rej[g]`.
  - If the winning entry's reject bit is 1, the character is dropped and excluded.
  - If the reject bit is 0, the character is written, included, and `buf_close` is raised.
- R9: Inside the escape window, a character that matches no enabled entry raises `buf_close` and `esc_err`, is neither written nor included, and closes the window.
- R10: With `esc_en` clear, or `xp_mode` low, a character equal to `esc_chr` is an ordinary character.
- R11: `xp_mode` low in any cycle closes the escape window, even without a strobe.
- R12: All comparisons span every bit of the character, so a parity bit in bit 7 takes part in every match.
- R13: An ordinary character is written and included, and `out_char` equals it in the cycle where `wr_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_vld | input | 1 | Character strobe from the assembler |
| rx_char | input | 8 | Assembled character (parity included) |
| xp_mode | input | 1 | Transparent mode select |
| hunt | input | 1 | Receiver hunting for synchronization |
| sync_chr | input | 8 | Synchronization character |
| sync_en | input | 1 | Synchronization character enable |
| esc_chr | input | 8 | Escape (DLE) character |
| esc_en | input | 1 | Escape character enable |
| tbl_val | input | 64 | Control table values, entry g in bits 8g+7..8g |
| tbl_en | input | 8 | Control table entry enables |
| tbl_rej | input | 8 | Control table reject bits |
| wr_en | output | 1 | Write character to buffer |
| bc_incl | output | 1 | Include character in block check |
| buf_close | output | 1 | Close current buffer |
| esc_err | output | 1 | Illegal character after escape |
| out_char | output | 8 | Character to write |

## Verification
The embedded properties check these on every cycle:

- the qualifiers are quiet after an empty cycle or a hunted strobe;
- an escape error always comes with a close and never with a write;
- every write is included in the check;
- the escape window only exists after transparent, non-hunting cycles;
- at most one table entry wins a lookup.

Some behaviour can only be shown by the bench's reference model running through its directed and randomized scenarios:

- what the filter does with each follower class;
- lowest-index priority between duplicate table entries;
- the window being cleared by mode changes with no strobe present;
- full-width comparison against parity-flipped characters.

// File: rtl/xpf_pkg.sv
package xpf_pkg;

   // decision for one strobed character
   typedef struct packed {
      logic wr;
      logic incl;
      logic close;
      logic err;
   } xpf_verdict_t;

   localparam xpf_verdict_t XPF_DROP = '{wr: 1'b0, incl: 1'b0, close: 1'b0, err: 1'b0};
   localparam xpf_verdict_t XPF_DATA = '{wr: 1'b1, incl: 1'b1, close: 1'b0, err: 1'b0};
   localparam xpf_verdict_t XPF_CTRL = '{wr: 1'b1, incl: 1'b1, close: 1'b1, err: 1'b0};
   localparam xpf_verdict_t XPF_FAIL = '{wr: 1'b0, incl: 1'b0, close: 1'b1, err: 1'b1};

endpackage

// File: rtl/xpf_ctl_table.sv
module xpf_ctl_table #(
   parameter int CW   = 8,
   parameter int NTAB = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [CW-1:0]       ch,
   input  logic [NTAB*CW-1:0]  tbl_val,
   input  logic [NTAB-1:0]     tbl_en,
   input  logic [NTAB-1:0]     tbl_rej,
   output logic                hit,
   output logic                rej
);

   logic [NTAB-1:0] eq;
   logic [NTAB-1:0] grant;

   generate
      if (NTAB < 1) begin : g_bad_ntab
         $error("xpf_ctl_table: NTAB must be at least 1");
      end
      for (genvar g = 0; g < NTAB; g++) begin : g_ent
         assign eq[g] = tbl_en[g] && (tbl_val[g*CW +: CW] == ch);
      end
   endgenerate

   // lowest index wins
   always_comb begin
      logic found;
      found = 1'b0;
      grant = '0;
      for (int i = 0; i < NTAB; i++) begin
         if (eq[i] && !found) begin
            grant[i] = 1'b1;
            found    = 1'b1;
         end
      end
   end

   assign hit = |grant;
   assign rej = |(grant & tbl_rej);

   // R8
   one_winner_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));

endmodule

// File: rtl/xpf_esc_fsm.sv
module xpf_esc_fsm
   import xpf_pkg::*;
(
   input  logic         clk,
   input  logic         rst,
   input  logic         strobe,
   input  logic         xp_mode,
   input  logic         hunt,
   input  logic         sync_en,
   input  logic         esc_en,
   input  logic         is_sync,
   input  logic         is_esc,
   input  logic         tbl_hit,
   input  logic         tbl_rej,
   output xpf_verdict_t vd,
   output logic         esc_q
);

   logic esc_act;
   logic esc_d;

   // window survives only in transparent, non-hunting cycles
   assign esc_act = esc_q && xp_mode && !hunt;

   always_comb begin
      vd    = XPF_DROP;
      esc_d = esc_act;
      if (strobe) begin
         if (hunt) begin
            vd    = XPF_DROP;
            esc_d = 1'b0;
         end else if (esc_act) begin
            esc_d = 1'b0;
            if (is_sync)      vd = XPF_DROP;
            else if (is_esc)  vd = XPF_DATA;
            else if (tbl_hit) vd = tbl_rej ? XPF_DROP : XPF_CTRL;
            else              vd = XPF_FAIL;
         end else if (sync_en && is_sync) begin
            vd = XPF_DROP;
         end else if (xp_mode && esc_en && is_esc) begin
            vd    = XPF_DROP;
            esc_d = 1'b1;
         end else begin
            vd = XPF_DATA;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) esc_q <= 1'b0;
      else     esc_q <= esc_d;
   end

   // R11
   esc_src_chk: assert property (@(posedge clk) disable iff (rst)
      esc_q |-> $past(xp_mode && !hunt));

   // R5
   esc_open_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(esc_q) |-> $past(strobe && is_esc && esc_en));

endmodule

// File: rtl/bsc_xp_filter.sv
module bsc_xp_filter
   import xpf_pkg::*;
#(
   parameter int CW   = 8,
   parameter int NTAB = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                rx_vld,
   input  logic [CW-1:0]       rx_char,
   input  logic                xp_mode,
   input  logic                hunt,
   input  logic [CW-1:0]       sync_chr,
   input  logic                sync_en,
   input  logic [CW-1:0]       esc_chr,
   input  logic                esc_en,
   input  logic [NTAB*CW-1:0]  tbl_val,
   input  logic [NTAB-1:0]     tbl_en,
   input  logic [NTAB-1:0]     tbl_rej,
   output logic                wr_en,
   output logic                bc_incl,
   output logic                buf_close,
   output logic                esc_err,
   output logic [CW-1:0]       out_char
);

   localparam int TBL_BITS = NTAB * CW;

   generate
      if (CW < 5 || CW > 16) begin : g_bad_cw
         $error("bsc_xp_filter: CW must lie in 5..16");
      end
      if (TBL_BITS > 4096) begin : g_bad_tbl
         $error("bsc_xp_filter: control table too large");
      end
   endgenerate

   logic         is_sync;
   logic         is_esc;
   logic         t_hit;
   logic         t_rej;
   logic         esc_q;
   xpf_verdict_t vd;
   xpf_verdict_t vd_q;
   logic [CW-1:0] char_q;

   // full-width compares, parity bit included
   assign is_sync = (rx_char == sync_chr);
   assign is_esc  = (rx_char == esc_chr);

   xpf_ctl_table #(.CW(CW), .NTAB(NTAB)) i_tbl (
      .clk     (clk),
      .rst     (rst),
      .ch      (rx_char),
      .tbl_val (tbl_val),
      .tbl_en  (tbl_en),
      .tbl_rej (tbl_rej),
      .hit     (t_hit),
      .rej     (t_rej)
   );

   xpf_esc_fsm i_fsm (
      .clk     (clk),
      .rst     (rst),
      .strobe  (rx_vld),
      .xp_mode (xp_mode),
      .hunt    (hunt),
      .sync_en (sync_en),
      .esc_en  (esc_en),
      .is_sync (is_sync),
      .is_esc  (is_esc),
      .tbl_hit (t_hit),
      .tbl_rej (t_rej),
      .vd      (vd),
      .esc_q   (esc_q)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         vd_q   <= XPF_DROP;
         char_q <= '0;
      end else begin
         vd_q <= vd;
         if (rx_vld) char_q <= rx_char;
      end
   end

   assign wr_en     = vd_q.wr;
   assign bc_incl   = vd_q.incl;
   assign buf_close = vd_q.close;
   assign esc_err   = vd_q.err;
   assign out_char  = char_q;

   // R2
   quiet_after_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rx_vld) |-> !(wr_en || bc_incl || buf_close || esc_err));

   // R3
   hunt_drop_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rx_vld && hunt) |-> !(wr_en || buf_close));

   // R9
   err_close_chk: assert property (@(posedge clk) disable iff (rst)
      esc_err |-> (buf_close && !wr_en && !bc_incl));

   // R13
   write_incl_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> bc_incl);

   // R5
   esc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(esc_q) |=> 1'b1 ##0 !$past(wr_en));

endmodule

// File: tb/test_bsc_xp_filter.sv
module test_bsc_xp_filter;

   localparam int CW = 8;
   localparam int NT = 8;

   logic clk = 1'b0;
   logic rst;
   logic rx_vld;
   logic [CW-1:0] rx_char;
   logic xp_mode, hunt, sync_en, esc_en;
   logic [CW-1:0] sync_chr, esc_chr;
   logic [NT*CW-1:0] tbl_val;
   logic [NT-1:0] tbl_en, tbl_rej;
   logic wr_en, bc_incl, buf_close, esc_err;
   logic [CW-1:0] out_char;

   logic [CW-1:0] tv [NT];

   int total = 0;
   int bad   = 0;

   // model state
   bit m_esc = 0;
   bit e_wr, e_in, e_cl, e_er;
   logic [CW-1:0] e_ch;
   string e_tag = "R1";

   always #10 clk = ~clk;

   always_comb
      for (int g = 0; g < NT; g++) tbl_val[g*CW +: CW] = tv[g];

   bsc_xp_filter i_bsc_xp_filter (
      .clk(clk), .rst(rst), .rx_vld(rx_vld), .rx_char(rx_char),
      .xp_mode(xp_mode), .hunt(hunt), .sync_chr(sync_chr), .sync_en(sync_en),
      .esc_chr(esc_chr), .esc_en(esc_en), .tbl_val(tbl_val), .tbl_en(tbl_en),
      .tbl_rej(tbl_rej), .wr_en(wr_en), .bc_incl(bc_incl), .buf_close(buf_close),
      .esc_err(esc_err), .out_char(out_char)
   );

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      #4_000_000;
      total++; bad++;
      $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
      summary();
      $finish;
   end

   // behavioural reference for one strobe, fills e_* and advances m_esc
   task automatic model(input bit v, input logic [CW-1:0] c);
      bit open;
      int win;
      open = m_esc && xp_mode && !hunt;
      {e_wr, e_in, e_cl, e_er} = 4'b0000;
      e_ch = c;
      m_esc = open;
      if (!v) begin
         e_tag = open ? "R11" : "R2";
         if (!xp_mode) e_tag = "R11";
         return;
      end
      if (hunt) begin
         e_tag = "R3"; m_esc = 0;
      end else if (open) begin
         m_esc = 0;
         if (c == sync_chr) e_tag = "R6";
         else if (c == esc_chr) begin e_tag = "R7"; e_wr = 1; e_in = 1; end
         else begin
            win = -1;
            for (int i = NT - 1; i >= 0; i--)
               if (tbl_en[i] && tv[i] == c) win = i;
            if (win < 0) begin e_tag = "R9"; e_cl = 1; e_er = 1; end
            else begin
               e_tag = "R8";
               if (!tbl_rej[win]) begin e_wr = 1; e_in = 1; e_cl = 1; end
            end
         end
      end else if (sync_en && c == sync_chr) begin
         e_tag = "R4";
      end else if (xp_mode && esc_en && c == esc_chr) begin
         e_tag = "R5"; m_esc = 1;
      end else begin
         e_tag = (c == esc_chr) ? "R10" : "R13";
         e_wr = 1; e_in = 1;
      end
   endtask

   task automatic check(input string tag);
      total++;
      if ({wr_en, bc_incl, buf_close, esc_err} !== {e_wr, e_in, e_cl, e_er} ||
          (e_wr && out_char !== e_ch)) begin
         bad++;
         $display("FAIL %s: actual wr/incl/close/err=%b%b%b%b char=%h expected=%b%b%b%b char=%h",
                  tag, wr_en, bc_incl, buf_close, esc_err, out_char,
                  e_wr, e_in, e_cl, e_er, e_ch);
      end
   endtask

   // drive at negedge, compare at the next negedge
   task automatic cyc(input bit v, input logic [CW-1:0] c);
      string t;
      rx_vld = v; rx_char = c;
      model(v, c);
      t = e_tag;
      @(negedge clk);
      check(t);
   endtask

   initial begin
      rst = 1; rx_vld = 1; rx_char = 8'h32;
      xp_mode = 1; hunt = 0;
      sync_chr = 8'h32; sync_en = 1;
      esc_chr = 8'h10; esc_en = 1;
      tv[0] = 8'h03; tv[1] = 8'h17; tv[2] = 8'h05; tv[3] = 8'h03;
      tv[4] = 8'h26; tv[5] = 8'h1F; tv[6] = 8'h2D; tv[7] = 8'hC4;
      tbl_en  = 8'b1110_1111;
      tbl_rej = 8'b0100_1100;
      repeat (3) @(negedge clk);
      {e_wr, e_in, e_cl, e_er} = 4'b0000;
      check("R1");
      rst = 0; rx_vld = 0;
      m_esc = 0;
      @(negedge clk);
      check("R1");

      // R13 ordinary data, R2 gaps
      cyc(1, 8'h41); cyc(1, 8'h42); cyc(0, 8'h00); cyc(1, 8'h7E);
      // R4 sync drop; R12 parity-flipped sync passes
      cyc(1, 8'h32); cyc(1, 8'hB2);
      sync_en = 0; cyc(1, 8'h32); sync_en = 1;
      // R5 + R7 doubled escape
      cyc(1, 8'h10); cyc(1, 8'h10);
      // R5 + R6 escaped sync, with sync_en clear
      sync_en = 0; cyc(1, 8'h10); cyc(1, 8'h32); sync_en = 1;
      // R8 accept (entry 0 beats rejecting duplicate 3)
      cyc(1, 8'h10); cyc(1, 8'h03);
      // R8 reject
      cyc(1, 8'h10); cyc(1, 8'h05);
      // R9 miss, disabled entry 4 also misses, R12 parity-flipped control
      cyc(1, 8'h10); cyc(1, 8'h55);
      cyc(1, 8'h10); cyc(1, 8'h26);
      cyc(1, 8'h10); cyc(1, 8'h83);
      // R10 escape disabled or non-transparent
      esc_en = 0; cyc(1, 8'h10); cyc(1, 8'h05); esc_en = 1;
      xp_mode = 0; cyc(1, 8'h10); cyc(1, 8'h05); xp_mode = 1;
      cyc(1, 8'h90);
      // R11 window cleared by leaving transparent mode with no strobe
      cyc(1, 8'h10); xp_mode = 0; cyc(0, 8'h00); xp_mode = 1; cyc(1, 8'h55);
      // R3 hunt drops and clears
      cyc(1, 8'h10); hunt = 1; cyc(0, 8'h00); cyc(1, 8'h41); hunt = 0; cyc(1, 8'h55);
      // window persists across gaps
      cyc(1, 8'h10); cyc(0, 8'h00); cyc(0, 8'h00); cyc(1, 8'h1F);

      // randomized traffic
      for (int n = 0; n < 4000; n++) begin
         int k;
         logic [CW-1:0] c;
         k = $urandom_range(0, 9);
         case (k)
            0, 1: c = esc_chr;
            2:    c = sync_chr;
            3, 4: c = tv[$urandom_range(0, NT - 1)];
            5:    c = esc_chr ^ 8'h80;
            default: c = CW'($urandom);
         endcase
         xp_mode = ($urandom_range(0, 19) != 0);
         hunt    = ($urandom_range(0, 29) == 0);
         sync_en = ($urandom_range(0, 7) != 0);
         esc_en  = ($urandom_range(0, 7) != 0);
         if ($urandom_range(0, 99) == 0) tbl_rej = NT'($urandom);
         cyc($urandom_range(0, 3) != 0, c);
      end

      summary();
      $finish;
   end

endmodule